// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a serial memory's four-wire link: select, clock, data in and data out, plus a pause input. It samples these pins with a fast system clock and shifts in an 8-bit instruction. After decoding the instruction it either collects an address and data bytes, or streams bytes back out on the data output. It does not hold the array, the status bits, the protection policy or the write timer. Instead it presents requests to three ports around it: a storage read port, a status port (write-latch set/clear pulses and a status byte write) and a page-write port that is fed one byte at a time and then told to commit.

Reads stream the array, advancing the byte address after every byte and wrapping over the whole array. Writes advance only the byte offset inside a page. While the external write cycle is busy, only the status read is honoured. A pause input freezes the frame at its current bit and takes the output off the bus until the frame resumes.

Top module: `sermem_front`

## Requirements
- R1: After reset, and whenever no output phase is running, `so_oe` is 0 and every strobe output (`wel_set`, `wel_clr`, `sr_wr_stb`, `pw_load_stb`, `pw_commit`, `mem_rd_stb`) is 0.
- R2: Bits are taken from the data input on rising serial clock edges and the output bit changes on falling edges, MSB first. This holds with the clock idling low (mode 0) and with it idling high (mode 3).
- R3: Only the instruction bytes 0x06 (write-latch set), 0x04 (write-latch clear), 0x05 (status read), 0x01 (status write), 0x03 (read) and 0x02 (write) are acted on. Any other byte leaves `so_oe` at 0 and raises no strobe for the rest of the frame.
- R4: 0x06 pulses `wel_set` and 0x04 pulses `wel_clr` on the select rise, but only if select rises straight after the eighth instruction bit. Any further rising clock edge cancels the pulse.
- R5: The status read shifts out `status_in` MSB first and repeats it every eight bits until select rises. It is accepted even while `wr_busy` is 1.
- R6: A read takes 16 address bits MSB first and uses the low 12. It then shifts out the byte found at `mem_addr`, adds one to the address after each byte, and wraps from 0xFFF to 0x000.
- R7: A write takes 16 address bits, then each complete data byte pulses `pw_load_stb` with `pw_addr` and `pw_data`. After each byte only the low 5 address bits advance, wrapping inside the 32-byte page. `pw_commit` pulses on a select rise that falls on a byte boundary after at least one data byte.
- R8: A status write pulses `sr_wr_stb` on the select rise, carrying the first data byte on `sr_wr_data`, only if select rises on a byte boundary after that byte.
- R9: If `wr_busy` is 1 when the instruction byte completes, any instruction other than 0x05 yields no output and no strobe.
- R10: Pause input low, taken while select is low and the clock is low, disables `so_oe` and ignores clock and data. Taking it high while the clock is low resumes the frame at the same bit.
- R11: A select rise in the middle of the instruction, the address or a data byte ends the frame without any strobe for the unfinished part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| si_pin | input | 1 | Serial data input pin |
| hold_n_pin | input | 1 | Pause pin, active low |
| so_data | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for the data output (0 = high impedance) |
| wr_busy | input | 1 | External write cycle in progress |
| status_in | input | 8 | Current status byte, shifted out by the status read |
| mem_addr | output | 12 | Storage read address |
| mem_rd_stb | output | 1 | One-cycle pulse when a read byte is taken from `mem_rd_data` |
| mem_rd_data | input | 8 | Storage byte at `mem_addr`, valid combinationally |
| wel_set | output | 1 | Write-latch set pulse |
| wel_clr | output | 1 | Write-latch clear pulse |
| sr_wr_stb | output | 1 | Status write pulse |
| sr_wr_data | output | 8 | Byte for the status write |
| pw_load_stb | output | 1 | Page-buffer byte load pulse |
| pw_addr | output | 12 | Address for the loaded byte |
| pw_data | output | 8 | Loaded data byte |
| pw_commit | output | 1 | Page-write start pulse |

## Verification
Every pin passes through a two-flop synchronizer and one edge register, so the frame registers react on the third system clock edge after a pin change. Strobes and the output bit therefore appear three cycles after the serial edge that causes them. The bench holds each serial half period for six system cycles and samples the output only at the end of a half period. By then the reaction is complete and the next edge has not yet been applied. Strobes are counted continuously, and the counts are compared after each frame has ended and its select rise has had time to pass through the synchronizer.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_DIN, PH_DOUT, PH_ARMED, PH_DROP
  } phase_t;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
endpackage

// File: rtl/sermem_pin_sync.sv
module sermem_pin_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL[i]}};
      else        chain <= {chain[STAGES-1:0], pins[i]};
    end
    assign lvl[i]  = chain[STAGES-1];
    assign rise[i] = chain[STAGES-1] & ~chain[STAGES];
    assign fall[i] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/sermem_hold_gate.sv
module sermem_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_lvl,
  input  logic sck_lvl,
  input  logic hold_rise,
  input  logic hold_fall,
  output logic held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      held <= 1'b0;
    else if (cs_n_lvl)               held <= 1'b0;
    else if (hold_fall && !sck_lvl)  held <= 1'b1;
    else if (hold_rise && !sck_lvl)  held <= 1'b0;
  end
endmodule

// File: rtl/sermem_front.sv
module sermem_front
  import sermem_pkg::*;
#(
  parameter int AW          = 12,
  parameter int ADDR_BITS   = 16,
  parameter int PAGE_BITS   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_pin,
  input  logic          sck_pin,
  input  logic          si_pin,
  input  logic          hold_n_pin,
  output logic          so_data,
  output logic          so_oe,
  input  logic          wr_busy,
  input  logic [7:0]    status_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_stb,
  input  logic [7:0]    mem_rd_data,
  output logic          wel_set,
  output logic          wel_clr,
  output logic          sr_wr_stb,
  output logic [7:0]    sr_wr_data,
  output logic          pw_load_stb,
  output logic [AW-1:0] pw_addr,
  output logic [7:0]    pw_data,
  output logic          pw_commit
);
  localparam int ACW = $clog2(ADDR_BITS);

  function automatic logic [AW-1:0] read_next(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
    logic [PAGE_BITS-1:0] lo;
    lo = a[PAGE_BITS-1:0] + 1'b1;
    return {a[AW-1:PAGE_BITS], lo};
  endfunction

  // pin order {hold_n, si, sck, cs_n}
  logic [3:0] p_lvl, p_rise, p_fall;
  sermem_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk, .rst_n,
    .pins ({hold_n_pin, si_pin, sck_pin, cs_n_pin}),
    .lvl  (p_lvl), .rise (p_rise), .fall (p_fall)
  );

  logic cs_lvl, sck_lvl, si_lvl, held;
  assign cs_lvl  = p_lvl[0];
  assign sck_lvl = p_lvl[1];
  assign si_lvl  = p_lvl[2];

  sermem_hold_gate u_hold (
    .clk, .rst_n, .cs_n_lvl(cs_lvl), .sck_lvl(sck_lvl),
    .hold_rise(p_rise[3]), .hold_fall(p_fall[3]), .held(held)
  );

  phase_t         phase;
  logic [2:0]     bit_cnt;
  logic [ACW-1:0] addr_cnt;
  logic [7:0]     sh_in, opcode, out_sh;
  logic [AW-1:0]  addr_q;
  logic           byte_have, so_q, oe_q, ld_pend;

  // named internal events
  logic       sck_r, sck_f, frame_start, frame_end;
  logic       opc_done, addr_done, din_done, dout_wrap;
  logic [7:0] op_word;
  assign sck_r       = p_rise[1] & ~held & ~cs_lvl;
  assign sck_f       = p_fall[1] & ~held & ~cs_lvl;
  assign frame_start = p_fall[0];
  assign frame_end   = p_rise[0];
  assign op_word     = {sh_in[6:0], si_lvl};
  assign opc_done    = (phase == PH_OPC)  && sck_r && (bit_cnt == 3'd7);
  assign addr_done   = (phase == PH_ADDR) && sck_r && (addr_cnt == ACW'(ADDR_BITS-1));
  assign din_done    = (phase == PH_DIN)  && sck_r && (bit_cnt == 3'd7);
  assign dout_wrap   = (phase == PH_DOUT) && sck_f && (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bit_cnt <= '0; addr_cnt <= '0;
      sh_in <= '0; opcode <= '0; out_sh <= '0; addr_q <= '0;
      byte_have <= 1'b0; so_q <= 1'b0; oe_q <= 1'b0; ld_pend <= 1'b0;
      wel_set <= 1'b0; wel_clr <= 1'b0; sr_wr_stb <= 1'b0; sr_wr_data <= '0;
      pw_load_stb <= 1'b0; pw_addr <= '0; pw_data <= '0; pw_commit <= 1'b0;
    end else begin
      wel_set <= 1'b0; wel_clr <= 1'b0; sr_wr_stb <= 1'b0;
      pw_load_stb <= 1'b0; pw_commit <= 1'b0;
      if (frame_end) begin
        if (phase == PH_ARMED) begin
          wel_set <= (opcode == OP_WREN);
          wel_clr <= (opcode == OP_WRDI);
        end
        if (phase == PH_DIN && byte_have && bit_cnt == 3'd0) begin
          sr_wr_stb <= (opcode == OP_WRSR);
          pw_commit <= (opcode == OP_WRITE);
        end
        phase <= PH_IDLE; oe_q <= 1'b0; ld_pend <= 1'b0;
      end else if (frame_start) begin
        phase <= PH_OPC; bit_cnt <= '0; byte_have <= 1'b0; oe_q <= 1'b0;
      end else begin
        unique case (phase)
          PH_OPC: if (sck_r) begin
            sh_in   <= op_word;
            bit_cnt <= bit_cnt + 3'd1;
            if (opc_done) begin
              opcode <= op_word;
              if (wr_busy && op_word != OP_RDSR) phase <= PH_DROP;
              else case (op_word)
                OP_WREN, OP_WRDI: phase <= PH_ARMED;
                OP_RDSR: begin phase <= PH_DOUT; ld_pend <= 1'b1; end
                OP_READ, OP_WRITE: begin phase <= PH_ADDR; addr_cnt <= '0; end
                OP_WRSR: phase <= PH_DIN;
                default: phase <= PH_DROP;
              endcase
            end
          end
          PH_ADDR: if (sck_r) begin
            addr_q   <= {addr_q[AW-2:0], si_lvl};
            addr_cnt <= addr_cnt + 1'b1;
            if (addr_done) begin
              phase   <= (opcode == OP_READ) ? PH_DOUT : PH_DIN;
              ld_pend <= (opcode == OP_READ);
            end
          end
          PH_DIN: if (sck_r) begin
            sh_in   <= op_word;
            bit_cnt <= bit_cnt + 3'd1;
            if (din_done) begin
              byte_have <= 1'b1;
              if (opcode == OP_WRITE) begin
                pw_load_stb <= 1'b1;
                pw_addr     <= addr_q;
                pw_data     <= op_word;
                addr_q      <= page_next(addr_q);
              end else if (!byte_have) begin
                sr_wr_data <= op_word;
              end
            end
          end
          PH_DOUT: begin
            if (ld_pend) begin
              out_sh  <= (opcode == OP_RDSR) ? status_in : mem_rd_data;
              ld_pend <= 1'b0;
            end else if (sck_f) begin
              so_q    <= out_sh[7];
              out_sh  <= {out_sh[6:0], 1'b0};
              oe_q    <= 1'b1;
              bit_cnt <= bit_cnt + 3'd1;
              if (dout_wrap) begin
                ld_pend <= 1'b1;
                if (opcode == OP_READ) addr_q <= read_next(addr_q);
              end
            end
          end
          PH_ARMED: if (sck_r) phase <= PH_DROP;
          default: ;
        endcase
      end
    end
  end

  assign mem_addr   = addr_q;
  assign mem_rd_stb = ld_pend && (phase == PH_DOUT) && (opcode == OP_READ);
  assign so_data    = so_q;
  assign so_oe      = oe_q & ~held & ~cs_lvl;
endmodule

// File: rtl/sermem_front_chk.sv
module sermem_front_chk
  import sermem_pkg::*;
#(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_end,
  input logic          opc_done,
  input logic          din_done,
  input logic          dout_wrap,
  input logic          held,
  input logic          so_oe,
  input logic          wel_set,
  input logic          pw_load_stb,
  input logic          wr_busy,
  input logic [7:0]    op_word,
  input logic [7:0]    opcode,
  input phase_t        phase,
  input logic [2:0]    bit_cnt,
  input logic [AW-1:0] mem_addr
);
  assert_set_on_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wel_set |-> $past(frame_end));

  assert_load_after_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pw_load_stb |-> $past(din_done));

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_done && wr_busy && op_word != OP_RDSR) |=> (phase == PH_DROP));

  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(bit_cnt));

  assert_read_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_wrap && opcode == OP_READ) |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  assert_oe_only_in_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (phase == PH_DOUT));
endmodule

bind sermem_front sermem_front_chk #(.AW(AW)) u_chk (.*);

// File: tb/sermem_front_tb.sv
module sermem_front_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_pin = 1'b1, sck_pin = 1'b0, si_pin = 1'b0, hold_n_pin = 1'b1;
  logic wr_busy = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic so_data, so_oe, mem_rd_stb, wel_set, wel_clr, sr_wr_stb, pw_load_stb, pw_commit;
  logic [11:0] mem_addr, pw_addr;
  logic [7:0] mem_rd_data, sr_wr_data, pw_data;

  always #10 clk = ~clk;

  function automatic logic [7:0] mm(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction
  assign mem_rd_data = mm(mem_addr);

  sermem_front u_dut (.*);

  int n_wset = 0, n_wclr = 0, n_sr = 0, n_pwl = 0, n_pwc = 0, n_rd = 0;
  logic [7:0]  sr_last;
  logic [11:0] pw_a [0:15];
  logic [7:0]  pw_d [0:15];
  always @(posedge clk) begin
    if (wel_set) n_wset = n_wset + 1;
    if (wel_clr) n_wclr = n_wclr + 1;
    if (sr_wr_stb) begin n_sr = n_sr + 1; sr_last = sr_wr_data; end
    if (pw_commit) n_pwc = n_pwc + 1;
    if (mem_rd_stb) n_rd = n_rd + 1;
    if (pw_load_stb) begin
      pw_a[n_pwl % 16] = pw_addr; pw_d[n_pwl % 16] = pw_data; n_pwl = n_pwl + 1;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic m3 = 1'b0;
  logic [7:0] txb [0:9];
  logic [7:0] rxb [0:9];
  int         oec [0:9];
  int s_wset, s_wclr, s_sr, s_pwl, s_pwc, s_rd;

  task automatic snap();
    s_wset = n_wset; s_wclr = n_wclr; s_sr = n_sr; s_pwl = n_pwl; s_pwc = n_pwc; s_rd = n_rd;
  endtask

  task automatic bitx(input logic b, output logic s, output logic o);
    if (m3) sck_pin = 1'b0;
    si_pin = b;
    repeat (HALF) @(negedge clk);
    s = so_data; o = so_oe;
    sck_pin = 1'b1;
    repeat (HALF) @(negedge clk);
    if (!m3) sck_pin = 1'b0;
  endtask

  task automatic do_hold();
    repeat (HALF) @(negedge clk);
    hold_n_pin = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(so_oe == 1'b0, "R10 oe during pause", so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      si_pin = 1'($urandom);
      sck_pin = 1'b1; repeat (HALF) @(negedge clk);
      chk(so_oe == 1'b0, "R10 oe during pause clocks", so_oe, 0);
      sck_pin = 1'b0; repeat (HALF) @(negedge clk);
    end
    hold_n_pin = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_frame(input int nbytes, input int extra_bits, input int hold_at);
    logic s, o;
    sck_pin = m3;
    @(negedge clk); cs_n_pin = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbytes; b++) begin
      if (b == hold_at) do_hold();
      oec[b] = 0;
      for (int i = 7; i >= 0; i--) begin
        bitx(txb[b][i], s, o);
        rxb[b][i] = s;
        if (o) oec[b]++;
      end
    end
    for (int i = 0; i < extra_bits; i++) bitx(txb[nbytes][7-i], s, o);
    repeat (HALF) @(negedge clk);
    cs_n_pin = 1'b1;
    repeat (10) @(negedge clk);
    sck_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_test(input logic [15:0] a, input int n, input int hold_at);
    snap();
    txb[0] = 8'h03; txb[1] = a[15:8]; txb[2] = a[7:0];
    for (int k = 0; k < n; k++) txb[3+k] = 8'($urandom);
    do_frame(3 + n, 0, hold_at);
    for (int k = 0; k < n; k++) begin
      logic [11:0] ea;
      ea = a[11:0] + 12'(k);
      chk(rxb[3+k] == mm(ea), "R6 read data", rxb[3+k], mm(ea));
      chk(oec[3+k] == 8, "R2 output driven for data byte", oec[3+k], 8);
    end
    chk(oec[0] + oec[1] + oec[2] == 0, "R1 no output before data", oec[0] + oec[1] + oec[2], 0);
    chk(n_rd > s_rd, "R6 storage strobed", n_rd - s_rd, 1);
  endtask

  task automatic write_test(input logic [15:0] a, input int n);
    logic [11:0] ea;
    snap();
    txb[0] = 8'h02; txb[1] = a[15:8]; txb[2] = a[7:0];
    for (int k = 0; k < n; k++) txb[3+k] = 8'($urandom);
    do_frame(3 + n, 0, -1);
    chk(n_pwl - s_pwl == n, "R7 load count", n_pwl - s_pwl, n);
    chk(n_pwc - s_pwc == 1, "R7 commit", n_pwc - s_pwc, 1);
    ea = a[11:0];
    for (int k = 0; k < n; k++) begin
      chk(pw_a[(s_pwl + k) % 16] == ea, "R7 load address", pw_a[(s_pwl + k) % 16], ea);
      chk(pw_d[(s_pwl + k) % 16] == txb[3+k], "R7 load data", pw_d[(s_pwl + k) % 16], txb[3+k]);
      ea = (ea & 12'hFE0) | ((ea + 12'd1) & 12'h01F);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1 - 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(so_oe == 1'b0, "R1 reset oe", so_oe, 0);
    chk({wel_set, wel_clr, sr_wr_stb, pw_load_stb, pw_commit, mem_rd_stb} == 6'b0,
        "R1 reset strobes", {wel_set, wel_clr, sr_wr_stb, pw_load_stb, pw_commit, mem_rd_stb}, 0);

    // R4 write-latch set, mode 0 and clear, mode 3 (R2)
    snap(); txb[0] = 8'h06; do_frame(1, 0, -1);
    chk(n_wset - s_wset == 1, "R4 set pulse", n_wset - s_wset, 1);
    m3 = 1'b1; snap(); txb[0] = 8'h04; do_frame(1, 0, -1);
    chk(n_wclr - s_wclr == 1, "R4 R2 clear pulse mode 3", n_wclr - s_wclr, 1);
    m3 = 1'b0;
    // R4 extra clock cancels
    snap(); txb[0] = 8'h06; txb[1] = 8'h00; do_frame(1, 1, -1);
    chk(n_wset - s_wset == 0, "R4 extra clock cancels", n_wset - s_wset, 0);
    // R11 cut inside instruction
    snap(); txb[0] = 8'h06; do_frame(0, 5, -1);
    chk(n_wset - s_wset == 0, "R11 cut instruction", n_wset - s_wset, 0);

    // R5 status read
    status_in = 8'hA5; snap(); txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; do_frame(3, 0, -1);
    chk(rxb[1] == 8'hA5, "R5 status byte", rxb[1], 8'hA5);
    chk(rxb[2] == 8'hA5, "R5 status repeats", rxb[2], 8'hA5);
    m3 = 1'b1; wr_busy = 1'b1; status_in = 8'h81; do_frame(2, 0, -1);
    chk(rxb[1] == 8'h81, "R5 R9 status while busy mode 3", rxb[1], 8'h81);
    chk(oec[1] == 8, "R2 mode 3 output", oec[1], 8);

    // R9 other instructions while busy
    snap(); txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = 8'h10; txb[3] = 8'h00; do_frame(4, 0, -1);
    chk(oec[3] == 0 && n_rd == s_rd, "R9 read ignored busy", oec[3], 0);
    snap(); txb[0] = 8'h01; txb[1] = 8'h8C; do_frame(2, 0, -1);
    chk(n_sr - s_sr == 0, "R9 status write ignored busy", n_sr - s_sr, 0);
    snap(); txb[0] = 8'h06; do_frame(1, 0, -1);
    chk(n_wset - s_wset == 0, "R9 set ignored busy", n_wset - s_wset, 0);
    wr_busy = 1'b0; m3 = 1'b0;

    // R3 unknown instructions
    for (int t = 0; t < 4; t++) begin
      logic [7:0] op;
      op = (t == 0) ? 8'h07 : (t == 1) ? 8'hFF : 8'($urandom);
      if (op >= 8'h01 && op <= 8'h06) op = 8'h86;
      snap(); txb[0] = op; txb[1] = 8'h00; txb[2] = 8'h00; do_frame(3, 0, -1);
      chk(oec[1] + oec[2] == 0, "R3 unknown keeps output off", oec[1] + oec[2], 0);
      chk((n_wset - s_wset) + (n_wclr - s_wclr) + (n_sr - s_sr) + (n_pwl - s_pwl) + (n_pwc - s_pwc) + (n_rd - s_rd) == 0,
          "R3 unknown no strobe", n_pwl - s_pwl, 0);
    end

    // R8 status write
    snap(); txb[0] = 8'h01; txb[1] = 8'h8C; do_frame(2, 0, -1);
    chk(n_sr - s_sr == 1 && sr_last == 8'h8C, "R8 status write", sr_last, 8'h8C);
    snap(); txb[0] = 8'h01; txb[1] = 8'h44; txb[2] = 8'h00; do_frame(2, 3, -1);
    chk(n_sr - s_sr == 0, "R8 R11 off-boundary rise", n_sr - s_sr, 0);

    // R6 reads incl. wrap, R10 pause
    read_test(16'hF123, 3, -1);
    read_test(16'h0FFE, 4, -1);
    read_test(16'h0456, 3, 4);
    m3 = 1'b1; read_test(16'h3FFF, 2, -1); m3 = 1'b0;

    // R7 writes with page wrap
    write_test(16'h001E, 4);
    write_test(16'hA3FF, 2);
    // R11 cut inside data byte and address
    snap(); txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h40; txb[3] = 8'h11; txb[4] = 8'h22;
    do_frame(4, 4, -1);
    chk(n_pwl - s_pwl == 1 && n_pwc == s_pwc, "R11 R7 cut data byte", n_pwc - s_pwc, 0);
    snap(); txb[0] = 8'h03; txb[1] = 8'h01; do_frame(2, 3, -1);
    chk(n_rd == s_rd, "R11 cut address", n_rd - s_rd, 0);

    // constrained random mix
    for (int it = 0; it < 8; it++) begin
      logic [15:0] ra;
      m3 = 1'($urandom);
      ra = 16'($urandom);
      if (it % 2 == 0) read_test(ra, 1 + int'($urandom % 4), -1);
      else             write_test(ra, 1 + int'($urandom % 5));
    end
    m3 = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule